// File: doc/BRIEF.md
# Packed Block Protection Store

This block keeps a 2-bit protection level for each of up to 256 flash blocks. The levels sit in a table of bytes, four levels per byte. A lookup port takes a block number. One clock later it returns that block's level, along with three permission flags: external read allowed, external write allowed, and internal write allowed. Internal write covers internally issued write and erase commands.

Protection can only rise during normal operation. An update port takes one byte of a protection image per cycle. The image is 64 bytes long and is taken from SRAM starting at address 80h. Each incoming byte is ORed into the matching table byte, so a stored bit can never be cleared by an update. The only way to lower protection is the erase-all input, which writes zeros into the whole table in one cycle.

Top module: `prot_store`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the table holds only zeros. The outputs show level 00b with all three permission flags at 1.
- R2: The level of block b is stored in table byte b/4, at bits [2*(b mod 4)+1 : 2*(b mod 4)]. Byte 0 holds blocks 0 to 3 (block 0 in bits 1:0, block 3 in bits 7:6), and byte 63 holds blocks 252 to 255.
- R3: `lookup_blk` is sampled on a rising edge. The level and permission flags for it appear after that same edge and come from the table contents before any write at that edge.
- R4: When `upd_valid` is high, table byte `upd_idx` becomes its old value ORed with `upd_byte`. Stored levels therefore never decrease through an update, and an update byte of 00h changes nothing.
- R5: An update changes only table byte `upd_idx`. All other blocks keep their levels.
- R6: When `erase_all` is high, every table byte becomes 00h at that edge.
- R7: If `erase_all` and `upd_valid` are both high in the same cycle, the erase wins and the update is dropped.
- R8: Level codes map to the flags {ext_rd, ext_wr, int_wr} as follows: 00b gives {1,1,1}, 01b gives {0,1,1}, 10b gives {0,0,1}, and 11b gives {0,0,0}.
- R9: Image byte k is the byte read from SRAM address 80h+k. It is applied by driving `upd_idx` = k, for k from 0 to 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_blk | input | 8 | Block number to query |
| lookup_level | output | 2 | Registered level of the queried block |
| perm_ext_rd | output | 1 | External read allowed |
| perm_ext_wr | output | 1 | External write allowed |
| perm_int_wr | output | 1 | Internal write/erase allowed |
| upd_valid | input | 1 | Merge `upd_byte` into the table this cycle |
| upd_idx | input | 6 | Table byte index (image offset from 80h) |
| upd_byte | input | 8 | Protection image byte |
| erase_all | input | 1 | Clear the whole table |

## Verification
The table is first read while it is all zeros, which confirms the reset state. A staircase byte E4h is then written to byte 0. Because each of its four slots holds a different code, it exposes any slot-order or shift error and also covers all four flag decodings. Overlapping updates to byte 0 (01h, then 00h) show whether the block ORs or overwrites. A write of FFh to byte 1 must leave blocks 3 and 8 alone. Finally, a single cycle that carries both erase-all and an FFh update shows which of the two takes priority.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int LVL_W = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_OPEN      = 2'b00,
    LVL_NO_RD     = 2'b01,
    LVL_NO_EXT_WR = 2'b10,
    LVL_LOCKED    = 2'b11
  } prot_lvl_e;

  typedef struct packed {
    logic ext_rd;
    logic ext_wr;
    logic int_wr;
  } prot_perm_t;

  localparam prot_perm_t PERM_ALL = '{ext_rd: 1'b1, ext_wr: 1'b1, int_wr: 1'b1};
endpackage

// File: rtl/prot_table.sv
module prot_table #(
  parameter int DEPTH  = 64,
  parameter int BYTE_W = 8,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              erase_all,
  input  logic              upd_valid,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [BYTE_W-1:0] upd_byte,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [BYTE_W-1:0] rows [DEPTH];

  // Each row is its own register: erase must clear every row in one cycle.
  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst || erase_all) begin
        rows[r] <= '0;
      end else if (upd_valid && (upd_idx == IDX_W'(r))) begin
        rows[r] <= rows[r] | upd_byte;
      end
    end
  end

  assign rd_byte = rows[rd_idx];
endmodule

// File: rtl/prot_field_sel.sv
module prot_field_sel #(
  parameter int BYTE_W = 8,
  parameter int LVL_W  = 2,
  parameter int SLOTS  = BYTE_W / LVL_W,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [SLOT_W-1:0] slot,
  output logic [LVL_W-1:0]  lvl
);
  logic [LVL_W-1:0] fields [SLOTS];

  // The lowest numbered block sits in the lowest bits.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign fields[s] = byte_in[s*LVL_W +: LVL_W];
  end

  assign lvl = fields[slot];
endmodule

// File: rtl/prot_perm_decode.sv
module prot_perm_decode
  import prot_pkg::*;
(
  input  prot_lvl_e  lvl,
  output prot_perm_t perm
);
  always_comb begin
    perm = PERM_ALL;
    unique case (lvl)
      LVL_OPEN:      perm = PERM_ALL;
      LVL_NO_RD:     perm = '{ext_rd: 1'b0, ext_wr: 1'b1, int_wr: 1'b1};
      LVL_NO_EXT_WR: perm = '{ext_rd: 1'b0, ext_wr: 1'b0, int_wr: 1'b1};
      LVL_LOCKED:    perm = '{ext_rd: 1'b0, ext_wr: 1'b0, int_wr: 1'b0};
      default:       perm = PERM_ALL;
    endcase
  end
endmodule

// File: rtl/prot_store.sv
module prot_store
  import prot_pkg::*;
#(
  parameter int NUM_BLOCKS = 256,
  parameter int BYTE_W     = 8
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic [$clog2(NUM_BLOCKS)-1:0]                 lookup_blk,
  output logic [1:0]                                    lookup_level,
  output logic                                          perm_ext_rd,
  output logic                                          perm_ext_wr,
  output logic                                          perm_int_wr,
  input  logic                                          upd_valid,
  input  logic [$clog2(NUM_BLOCKS*LVL_W/BYTE_W)-1:0]    upd_idx,
  input  logic [BYTE_W-1:0]                             upd_byte,
  input  logic                                          erase_all
);
  localparam int SLOTS  = BYTE_W / LVL_W;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int DEPTH  = NUM_BLOCKS / SLOTS;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int BLK_W  = IDX_W + SLOT_W;

  logic [IDX_W-1:0]  rd_idx;
  logic [SLOT_W-1:0] rd_slot;
  logic [BYTE_W-1:0] rd_byte;
  logic [LVL_W-1:0]  lvl_raw;
  prot_lvl_e         lvl_c;
  prot_perm_t        perm_c;
  prot_lvl_e         lvl_q;
  prot_perm_t        perm_q;

  // Block number splits into byte index (upper bits) and slot (lower bits).
  assign rd_slot = lookup_blk[SLOT_W-1:0];
  assign rd_idx  = lookup_blk[BLK_W-1:SLOT_W];

  prot_table #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_table (
    .clk       (clk),
    .rst       (rst),
    .erase_all (erase_all),
    .upd_valid (upd_valid),
    .upd_idx   (upd_idx),
    .upd_byte  (upd_byte),
    .rd_idx    (rd_idx),
    .rd_byte   (rd_byte)
  );

  prot_field_sel #(.BYTE_W(BYTE_W), .LVL_W(LVL_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_sel (
    .byte_in (rd_byte),
    .slot    (rd_slot),
    .lvl     (lvl_raw)
  );

  assign lvl_c = prot_lvl_e'(lvl_raw);

  prot_perm_decode u_dec (
    .lvl  (lvl_c),
    .perm (perm_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= LVL_OPEN;
      perm_q <= PERM_ALL;
    end else begin
      lvl_q  <= lvl_c;
      perm_q <= perm_c;
    end
  end

  assign lookup_level = lvl_q;
  assign perm_ext_rd  = perm_q.ext_rd;
  assign perm_ext_wr  = perm_q.ext_wr;
  assign perm_int_wr  = perm_q.int_wr;
endmodule

// File: rtl/prot_store_chk.sv
module prot_store_chk #(
  parameter int BLK_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [BLK_W-1:0] lookup_blk,
  input logic [1:0]       lookup_level,
  input logic             perm_ext_rd,
  input logic             perm_ext_wr,
  input logic             perm_int_wr,
  input logic             erase_all
);
  // R8: permissions are nested; read allowed implies writes allowed.
  assert_perm_nest_R8: assert property (@(posedge clk) disable iff (rst)
    (perm_ext_rd |-> perm_ext_wr) and (perm_ext_wr |-> perm_int_wr));

  // R1: first cycle out of reset shows an open level with all flags set.
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lookup_level == 2'b00 && perm_ext_rd && perm_ext_wr && perm_int_wr));

  // R6: two edges after an erase, the looked-up level is open.
  assert_erase_clears_R6: assert property (@(posedge clk) disable iff (rst)
    erase_all |-> ##2 (lookup_level == 2'b00));

  // R4: repeated lookups of one block never see the level fall without erase.
  assert_no_lowering_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(lookup_blk) == $past(lookup_blk, 2) && !$past(erase_all, 2) && !$past(rst, 2))
      |-> (lookup_level >= $past(lookup_level)));
endmodule

bind prot_store prot_store_chk #(.BLK_W($clog2(NUM_BLOCKS))) u_chk (
  .clk          (clk),
  .rst          (rst),
  .lookup_blk   (lookup_blk),
  .lookup_level (lookup_level),
  .perm_ext_rd  (perm_ext_rd),
  .perm_ext_wr  (perm_ext_wr),
  .perm_int_wr  (perm_int_wr),
  .erase_all    (erase_all)
);

// File: tb/prot_store_test.sv
module prot_store_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] lookup_blk = '0;
  logic [1:0] lookup_level;
  logic       perm_ext_rd, perm_ext_wr, perm_int_wr;
  logic       upd_valid = 1'b0;
  logic [5:0] upd_idx = '0;
  logic [7:0] upd_byte = '0;
  logic       erase_all = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  prot_store uut (
    .clk(clk), .rst(rst), .lookup_blk(lookup_blk), .lookup_level(lookup_level),
    .perm_ext_rd(perm_ext_rd), .perm_ext_wr(perm_ext_wr), .perm_int_wr(perm_int_wr),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_byte(upd_byte), .erase_all(erase_all)
  );

  typedef struct {
    logic [1:0] lvl;
    logic [2:0] perm;
    string      req;
  } exp_t;

  exp_t       sb[$];
  logic [7:0] model [64];
  logic       lk_req = 1'b0;
  logic       lk_req_d = 1'b0;

  function automatic logic [2:0] perm_of(input logic [1:0] l);
    case (l)
      2'b00:   return 3'b111;
      2'b01:   return 3'b011;
      2'b10:   return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  // Driver: one lookup per cycle, expected value pushed to the scoreboard.
  task automatic lookup(input int blk, input string req);
    exp_t e;
    @(negedge clk);
    lookup_blk = 8'(blk);
    lk_req = 1'b1;
    e.lvl  = model[blk / 4][2*(blk % 4) +: 2];
    e.perm = perm_of(e.lvl);
    e.req  = req;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    lk_req = 1'b0;
    upd_valid = 1'b0;
    erase_all = 1'b0;
  endtask

  task automatic update(input int idx, input logic [7:0] b, input logic er);
    @(negedge clk);
    lk_req = 1'b0;
    upd_valid = 1'b1;
    upd_idx = 6'(idx);
    upd_byte = b;
    erase_all = er;
    if (er) begin
      for (int i = 0; i < 64; i++) model[i] = 8'h00;
    end else begin
      model[idx] = model[idx] | b;
    end
  endtask

  always @(posedge clk) lk_req_d <= lk_req;

  // Monitor: result of a lookup is checked one edge after it was sampled (R3).
  always @(negedge clk) begin
    if (lk_req_d && !rst) begin
      exp_t e;
      logic [2:0] act;
      e = sb.pop_front();
      act = {perm_ext_rd, perm_ext_wr, perm_int_wr};
      checks++;
      if (lookup_level !== e.lvl || act !== e.perm) begin
        fails++;
        $display("FAIL %s (R3 timing): level=%b perms=%b expected level=%b perms=%b",
                 e.req, lookup_level, act, e.lvl, e.perm);
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    checks++;
    if (lookup_level !== 2'b00 || {perm_ext_rd, perm_ext_wr, perm_int_wr} !== 3'b111) begin
      fails++;
      $display("FAIL R1: level=%b perms=%b expected 00/111", lookup_level,
               {perm_ext_rd, perm_ext_wr, perm_int_wr});
    end
    @(negedge clk) rst = 1'b0;

    lookup(0, "R1"); lookup(5, "R1"); lookup(255, "R1");
    // Staircase byte exposes slot order and every level code.
    update(0, 8'hE4, 1'b0); idle();
    lookup(0, "R2/R8"); lookup(1, "R2/R8"); lookup(2, "R2/R8"); lookup(3, "R2/R8");
    // Last image byte (SRAM 80h+63) drives blocks 252..255.
    update(63, 8'h40, 1'b0); idle();
    lookup(255, "R9"); lookup(252, "R9");
    // OR merge: new bits raise, zero byte lowers nothing.
    update(0, 8'h01, 1'b0); update(0, 8'h00, 1'b0); idle();
    lookup(0, "R4"); lookup(1, "R4"); lookup(3, "R4");
    // Write one byte, neighbours untouched.
    update(1, 8'hFF, 1'b0); idle();
    lookup(4, "R5"); lookup(7, "R5"); lookup(3, "R5"); lookup(8, "R5");
    // Erase and update together: erase wins.
    update(2, 8'hFF, 1'b1); idle();
    lookup(8, "R7"); lookup(11, "R7"); lookup(0, "R6"); lookup(255, "R6"); lookup(7, "R6");
    idle(); idle(); idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule